// File: doc/BRIEF.md
# Three-Channel Interval Timer

The block holds three independent up-counters, each with its own power-of-two prescaler, a stop/run control, an interval compare that restarts the count, and a latched interval event that drives a level interrupt. Software reaches every channel through one register bus. A register is read or written in a single clock cycle, with a read strobe, a write strobe and a byte address. The same register of channel n sits at the channel-0 address plus 4·n.

Each channel can take its count source from the core clock or from an external tick input, selected by a bit in its clock control register. The external tick is used as an enable with no synchroniser. The interval status bit is cleared by reading it. The interrupt output of a channel is high while the status bit and its enable bit are both set.

Top module: `tri_timer`

## Requirements
- R1: Channel-0 byte addresses are: clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54, interrupt enable 0x60. Channel n adds 4·n to each. A read of any other address, including a non-word-aligned one, returns 0.
- R2: Clock control holds three fields: bit 0 prescale enable, bits [4:1] code P, bit 5 source select. With the enable set, the count advances once per 2^(P+1) source ticks. With it clear, the count advances on every source tick. Writing the counter reset restarts the prescale phase.
- R3: After reset, counter control reads 0x01 (stopped), and every other register reads 0. While counter control bit 0 is 1 the count holds. While it is 0 the count advances.
- R4: Writing 1 to counter control bit 4 sets the count to 0 on that write's clock edge. The bit is not stored and always reads back as 0.
- R5: With interval mode off, a CNT_W-bit count wraps from all ones to 0 and does not set the status bit.
- R6: With interval mode on (counter control bit 1), the step taken while the count equals the interval register sends the count to 0 and sets status bit 0.
- R7: Reading the status register returns the latched bit and clears it.
- R8: A channel's interrupt output equals its status bit AND interrupt enable bit 0. With the enable clear, the output stays low.
- R9: Counter control bit 5 is stored and read back but changes no behaviour. Bits 2, 3 and 6 to 31 of counter control read as 0.
- R10: With clock control bit 5 set, the count source is the ext_tick_i input. With the bit clear, the source is every clock cycle.
- R11: If an interval event and a status read fall in the same cycle, the read returns the old value and the status bit is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_tick_i | input | 1 | Alternate count source, one tick per high cycle |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | AW | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle rd_i is high |
| irq_o | output | NUM_CH | Level interrupt, one per channel |

## Verification
The bench builds the default parameters: NUM_CH = 3, CNT_W = 16 and AW = 8. With a 16-bit count, a full wrap from all ones back to zero takes about 65,536 clocks, so the bench runs one complete wrap. Prescale codes 0 and 2 are timed exactly against their divide ratios. Address decode is checked at all three channel strides. The interval event is made to coincide with a status read, to show that the event is not lost when the two share a cycle.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam logic [7:0] OFS_CLK = 8'h00;
  localparam logic [7:0] OFS_CTL = 8'h0C;
  localparam logic [7:0] OFS_CNT = 8'h18;
  localparam logic [7:0] OFS_IVL = 8'h24;
  localparam logic [7:0] OFS_ISR = 8'h54;
  localparam logic [7:0] OFS_IER = 8'h60;
  localparam int CH_STRIDE = 4;
  localparam int CODE_W = 4;

  // bit order matches the clock control layout [5:0]
  typedef struct packed {
    logic              csel;
    logic [CODE_W-1:0] code;
    logic              pen;
  } clk_cfg_t;

  typedef struct packed {
    logic wave;
    logic ivl;
    logic stop;
  } cnt_cfg_t;
endpackage

// File: rtl/tri_timer_prescale.sv
module tri_timer_prescale #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              step_o
);
  localparam int DIV_W = (1 << CODE_W) + 1;

  logic [DIV_W-1:0] pcnt_q, last;
  logic [CODE_W:0]  sh;
  logic             adv, at_end;

  assign sh     = {1'b0, code_i} + (CODE_W+1)'(1);
  assign last   = (DIV_W'(1) << sh) - DIV_W'(1);
  assign adv    = run_i & tick_i;
  assign at_end = pcnt_q >= last;
  assign step_o = adv & (~en_i | at_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pcnt_q <= '0;
    else if (clr_i)         pcnt_q <= '0;
    else if (adv && en_i)   pcnt_q <= at_end ? '0 : pcnt_q + DIV_W'(1);
  end

  assert_prescale_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && en_i && !clr_i) |=> (pcnt_q == '0));
endmodule

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
  import tri_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_tick_i,
  input  logic             wr_clk_i,
  input  logic             wr_ctl_i,
  input  logic             wr_ivl_i,
  input  logic             wr_ier_i,
  input  logic             rd_isr_i,
  input  logic [31:0]      wdata_i,
  output clk_cfg_t         clk_cfg_o,
  output cnt_cfg_t         cnt_cfg_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] ivl_o,
  output logic             isr_o,
  output logic             ier_o,
  output logic             irq_o
);
  clk_cfg_t         clk_q;
  cnt_cfg_t         ctl_q;
  logic [CNT_W-1:0] count_q, ivl_q;
  logic             isr_q, ier_q;
  logic             cnt_clr, src_tick, step, hit, isr_set;
  logic             unused_wd;

  assign unused_wd = ^wdata_i;
  assign cnt_clr   = wr_ctl_i & wdata_i[4];
  assign src_tick  = clk_q.csel ? ext_tick_i : 1'b1;
  assign hit       = ctl_q.ivl && (count_q == ivl_q);
  assign isr_set   = step & hit & ~cnt_clr;

  tri_timer_prescale #(.CODE_W(CODE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .run_i  (~ctl_q.stop),
    .tick_i (src_tick),
    .en_i   (clk_q.pen),
    .code_i (clk_q.code),
    .step_o (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q <= '0;
      ctl_q <= '{wave: 1'b0, ivl: 1'b0, stop: 1'b1};
      ivl_q <= '0;
      ier_q <= 1'b0;
    end else begin
      if (wr_clk_i) clk_q <= clk_cfg_t'(wdata_i[5:0]);
      if (wr_ctl_i) ctl_q <= '{wave: wdata_i[5], ivl: wdata_i[1], stop: wdata_i[0]};
      if (wr_ivl_i) ivl_q <= wdata_i[CNT_W-1:0];
      if (wr_ier_i) ier_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (cnt_clr) count_q <= '0;
    else if (step)    count_q <= hit ? '0 : count_q + CNT_W'(1);
  end

  // a new event wins over a clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= 1'b0;
    else         isr_q <= (isr_q & ~rd_isr_i) | isr_set;
  end

  assign clk_cfg_o = clk_q;
  assign cnt_cfg_o = ctl_q;
  assign count_o   = count_q;
  assign ivl_o     = ivl_q;
  assign isr_o     = isr_q;
  assign ier_o     = ier_q;
  assign irq_o     = isr_q & ier_q;

  assert_cnt_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr |=> (count_q == '0));
  assert_stop_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.stop && !cnt_clr) |=> $stable(count_q));
  assert_ivl_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && hit && !cnt_clr) |=> (count_q == '0));
  assert_event_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_set |=> isr_q);
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int AW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_tick_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  clk_cfg_t         clk_a   [NUM_CH];
  cnt_cfg_t         ctl_a   [NUM_CH];
  logic [CNT_W-1:0] count_a [NUM_CH];
  logic [CNT_W-1:0] ivl_a   [NUM_CH];
  logic [NUM_CH-1:0] isr_a, ier_a;

  function automatic logic [AW-1:0] reg_addr(logic [7:0] ofs, int ch);
    return AW'(int'(ofs) + CH_STRIDE * ch);
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tri_timer_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ext_tick_i (ext_tick_i),
      .wr_clk_i   (wr_i && addr_i == reg_addr(OFS_CLK, c)),
      .wr_ctl_i   (wr_i && addr_i == reg_addr(OFS_CTL, c)),
      .wr_ivl_i   (wr_i && addr_i == reg_addr(OFS_IVL, c)),
      .wr_ier_i   (wr_i && addr_i == reg_addr(OFS_IER, c)),
      .rd_isr_i   (rd_i && addr_i == reg_addr(OFS_ISR, c)),
      .wdata_i    (wdata_i),
      .clk_cfg_o  (clk_a[c]),
      .cnt_cfg_o  (ctl_a[c]),
      .count_o    (count_a[c]),
      .ivl_o      (ivl_a[c]),
      .isr_o      (isr_a[c]),
      .ier_o      (ier_a[c]),
      .irq_o      (irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr_i == reg_addr(OFS_CLK, c)) rdata_o = {26'b0, clk_a[c]};
      if (addr_i == reg_addr(OFS_CTL, c)) rdata_o = {26'b0, ctl_a[c].wave, 3'b0, ctl_a[c].ivl, ctl_a[c].stop};
      if (addr_i == reg_addr(OFS_CNT, c)) rdata_o = 32'(count_a[c]);
      if (addr_i == reg_addr(OFS_IVL, c)) rdata_o = 32'(ivl_a[c]);
      if (addr_i == reg_addr(OFS_ISR, c)) rdata_o = {31'b0, isr_a[c]};
      if (addr_i == reg_addr(OFS_IER, c)) rdata_o = {31'b0, ier_a[c]};
    end
  end

  assert_unaligned_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[1:0] != 2'b00) |-> (rdata_o == '0));
endmodule

// File: tb/sim_tri_timer.sv
module sim_tri_timer;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;
  localparam int AW     = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ext_tick_i = 1'b0;
  logic              wr_i = 1'b0, rd_i = 1'b0;
  logic [AW-1:0]     addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [31:0]       rdata_o;
  logic [NUM_CH-1:0] irq_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  tri_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ext_tick_i(ext_tick_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [AW-1:0] ra(int ofs, int ch);
    return AW'(ofs + 4 * ch);
  endfunction

  task automatic op_start();
    @(posedge clk); #1;
    wr_i = 1'b0; rd_i = 1'b0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    op_start();
    wr_i = 1'b1; addr_i = AW'(a); wdata_i = d;
  endtask

  task automatic rd(int a, logic [31:0] e, string tag);
    item_t it;
    op_start();
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rd_i = 1'b1; addr_i = AW'(a);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) op_start();
  endtask

  task automatic chk_irq(logic [NUM_CH-1:0] e, string tag);
    @(negedge clk);
    n_cmp++;
    if (irq_o !== e) begin
      n_bad++;
      $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, e);
    end
  endtask

  // monitor: compares each read as the design returns it
  always @(negedge clk) begin
    if (rd_i) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 unexpected read actual=%h expected=none", rdata_o);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (rdata_o !== it.exp) begin
          n_bad++;
          $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata_o, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R3 reset state
    rd(ra('h0C, 0), 32'h1, "R3 ctl reset");
    rd(ra('h18, 0), 32'h0, "R3 count reset");
    rd(ra('h00, 1), 32'h0, "R3 clk reset");
    rd(ra('h24, 2), 32'h0, "R3 ivl reset");
    rd(ra('h60, 0), 32'h0, "R3 ier reset");
    chk_irq('0, "R3 irq reset");

    // R1 address stride and unmapped reads
    wr(ra('h24, 2), 32'h1234);
    rd(ra('h24, 2), 32'h1234, "R1 ch2 interval");
    rd(ra('h24, 1), 32'h0, "R1 ch1 interval untouched");
    rd(ra('h24, 0), 32'h0, "R1 ch0 interval untouched");
    rd('h25, 32'h0, "R1 unaligned");
    rd('h30, 32'h0, "R1 unmapped");

    // R9 stored no-effect bit and zero bits
    wr(ra('h0C, 1), 32'hFF);
    rd(ra('h0C, 1), 32'h23, "R9 ctl readback");
    rd(ra('h18, 1), 32'h0, "R9 count unaffected");
    wr(ra('h0C, 1), 32'h01);

    // R3 free count, no prescale: n idles -> n+1 steps
    wr(ra('h0C, 0), 32'h10);
    idle(9);
    wr(ra('h0C, 0), 32'h01);
    rd(ra('h18, 0), 32'd10, "R3 run count");
    rd(ra('h0C, 0), 32'h01, "R4 reset bit reads zero");
    wr(ra('h0C, 0), 32'h11);
    rd(ra('h18, 0), 32'h0, "R4 count cleared");
    idle(5);
    rd(ra('h18, 0), 32'h0, "R3 stopped holds");

    // R2 prescale code 0 (div 2) and code 2 (div 8)
    wr(ra('h00, 0), 32'h01);
    wr(ra('h0C, 0), 32'h10);
    idle(9);
    wr(ra('h0C, 0), 32'h01);
    rd(ra('h18, 0), 32'd5, "R2 div2 count");
    wr(ra('h00, 0), 32'h05);
    rd(ra('h00, 0), 32'h05, "R2 clk readback");
    wr(ra('h0C, 0), 32'h10);
    idle(19);
    wr(ra('h0C, 0), 32'h01);
    rd(ra('h18, 0), 32'd2, "R2 div8 count");

    // R10 external tick source
    wr(ra('h00, 2), 32'h20);
    wr(ra('h0C, 2), 32'h10);
    idle(5);
    wr(ra('h0C, 2), 32'h01);
    rd(ra('h18, 2), 32'h0, "R10 no ext tick");
    ext_tick_i = 1'b1;
    wr(ra('h0C, 2), 32'h10);
    idle(6);
    wr(ra('h0C, 2), 32'h01);
    rd(ra('h18, 2), 32'd7, "R10 ext tick count");
    idle(1);
    ext_tick_i = 1'b0;

    // R6 R7 R8 interval event on ch1
    wr(ra('h24, 1), 32'd4);
    wr(ra('h0C, 1), 32'h12);
    idle(4);
    wr(ra('h0C, 1), 32'h03);
    rd(ra('h18, 1), 32'h0, "R6 count restarted");
    chk_irq('0, "R8 gated by enable");
    wr(ra('h60, 1), 32'h1);
    idle(1);
    chk_irq(3'b010, "R8 irq raised");
    rd(ra('h54, 1), 32'h1, "R7 status set");
    rd(ra('h54, 1), 32'h0, "R7 status cleared");
    idle(1);
    chk_irq('0, "R8 irq dropped");

    // R5 full wrap without status
    wr(ra('h00, 0), 32'h00);
    wr(ra('h0C, 0), 32'h10);
    idle(65536);
    wr(ra('h0C, 0), 32'h01);
    rd(ra('h18, 0), 32'd1, "R5 wrapped count");
    rd(ra('h54, 0), 32'h0, "R5 no status on wrap");

    // R11 event and read in the same cycle
    wr(ra('h24, 0), 32'd2);
    wr(ra('h0C, 0), 32'h12);
    idle(2);
    rd(ra('h54, 0), 32'h0, "R11 read at event");
    wr(ra('h0C, 0), 32'h03);
    rd(ra('h54, 0), 32'h1, "R11 event kept");

    idle(2);
    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 pending reads actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule